// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block carries out one atomic memory operation at a time against a plain synchronous memory port. A caller presents the operand size code, the 32-bit operation selector, a base address, a signed 16-bit displacement, a source operand and the current accumulator (register zero) value, then pulses `start`. The unit reads the target location under a lock, forms the new value, writes it back, and finally reports the pre-update value so that the caller can update the source register or the accumulator.

The supported operations are add, or, and, xor, exchange and compare-exchange, on 32-bit or 64-bit data. A fetch modifier returns the old memory value. Compare-exchange always returns the old value to the accumulator and writes memory only when the comparison matches. Illegal size codes or selectors are rejected before any bus traffic takes place. The memory port returns read data exactly one cycle after a read strobe.

Top module: `atomic_rmw_unit`

## Requirements
- R1: The target address is `dstBase` plus `offset` sign-extended to 64 bits. Each accepted operation drives exactly one read cycle (`memRe`) with that address, and the address is unchanged on the following write cycle.
- R2: After the clock edge that accepts `start`, `memRe` is high for one cycle, the next cycle computes the result, `memWe` is high for the third cycle and `done` pulses in the fourth. `lock` is high from the read cycle through the write cycle, and is low when `done` is high.
- R3: Selector values 0x00, 0x40, 0x50 and 0xa0 write back old+src (wrapping), old|src, old&src and old^src.
- R4: `sizeCode` 0 selects a 32-bit operation: `memBe` is 0x0F, only bits 31:0 are compared and updated (bits 63:32 of memory keep their value), and returned values are zero-extended. `sizeCode` 3 selects a 64-bit operation with `memBe` 0xFF.
- R5: Selector bit 0 is the fetch flag. When set on an add, or, and, xor or exchange, `srcWe` pulses with `done` and `srcOut` holds the value memory had before the update. When clear, `srcWe` stays low.
- R6: Selector 0xe1 (exchange) writes `srcVal` to memory and returns the old value on `srcOut`.
- R7: Selector 0xf1 (compare-exchange) writes `srcVal` to memory when the old value equals `r0Val`. In every case it pulses `r0We` with `done`, with `r0Out` equal to the old value zero-extended, and leaves `srcWe` low.
- R8: A compare-exchange that does not match makes no write cycle, and `done` pulses in the third cycle after acceptance.
- R9: A `sizeCode` of 1 or 2, or any selector other than the ten legal values 0x00, 0x01, 0x40, 0x41, 0x50, 0x51, 0xa0, 0xa1, 0xe1, 0xf1 (bits 31:8 must be zero), pulses `error` in the cycle after `start`. The unit then makes no read and no write, does not pulse `done`, and stays idle.
- R10: `start` is ignored while `busy` is high. An operation in flight is neither restarted nor altered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled while idle) |
| sizeCode | input | 2 | Operand size: 0 = 32-bit, 3 = 64-bit |
| opImm | input | 32 | Operation selector |
| dstBase | input | 64 | Base address |
| offset | input | 16 | Signed displacement |
| srcVal | input | 64 | Source operand |
| r0Val | input | 64 | Comparison value for compare-exchange |
| busy | output | 1 | Operation in progress |
| lock | output | 1 | Memory location is held for this unit |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle rejection pulse |
| memAddr | output | 64 | Memory address |
| memRe | output | 1 | Read strobe |
| memWe | output | 1 | Write strobe |
| memBe | output | 8 | Byte strobes for the write |
| memWdata | output | 64 | Write data |
| memRdata | input | 64 | Read data, valid one cycle after `memRe` |
| srcOut | output | 64 | Fetched old value for the source register |
| srcWe | output | 1 | `srcOut` is to be written (with `done`) |
| r0Out | output | 64 | Old value for the accumulator |
| r0We | output | 1 | `r0Out` is to be written (with `done`) |

## Verification
Two functions can meet in one cycle. A new `start` can arrive while an operation is locked, and the compare decision and the result capture both happen in the cycle when read data returns. The bench raises `start` again, with a different selector and operand, in the read cycle of an operation in flight. It then judges that exactly one read and one write occur and that memory and the returned values match the first request alone. For compare-exchange, word operations whose upper halves differ but whose lower halves match must still write. Operations that match on the first try and operations that miss must both finish in their own fixed cycle counts.

// File: rtl/atomic_rmw_pkg.sv
package atomic_rmw_pkg;
  localparam int DATA_W = 64;
  localparam int HALF_W = DATA_W / 2;
  localparam int OFF_W  = 16;
  localparam int IMM_W  = 32;
  localparam int BE_W   = DATA_W / 8;

  localparam logic [1:0] SIZE_WORD  = 2'd0;
  localparam logic [1:0] SIZE_DWORD = 2'd3;

  localparam logic [7:0] OP_ADD  = 8'h00;
  localparam logic [7:0] OP_OR   = 8'h40;
  localparam logic [7:0] OP_AND  = 8'h50;
  localparam logic [7:0] OP_XOR  = 8'ha0;
  localparam logic [7:0] OP_XCHG = 8'he0;
  localparam logic [7:0] OP_CMPX = 8'hf0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_MODIFY, ST_WRITE, ST_DONE
  } rmwState_e;

  typedef struct packed {
    logic latchOp;
    logic readEn;
    logic capture;
    logic writeEn;
    logic finish;
  } rmwStrobe_t;

  function automatic logic opLegal(input logic [1:0] sz, input logic [IMM_W-1:0] imm);
    logic immOk;
    case ({imm[7:1], 1'b0})
      OP_ADD, OP_OR, OP_AND, OP_XOR: immOk = 1'b1;
      OP_XCHG, OP_CMPX:              immOk = imm[0];
      default:                       immOk = 1'b0;
    endcase
    return ((sz == SIZE_WORD) || (sz == SIZE_DWORD)) && (imm[IMM_W-1:8] == '0) && immOk;
  endfunction
endpackage

// File: rtl/atomic_rmw_ctrl.sv
module atomic_rmw_ctrl
  import atomic_rmw_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       opOk,
  input  logic       cmpMiss,
  output rmwStrobe_t strobe,
  output logic       lock,
  output logic       busy,
  output logic       error
);
  rmwState_e stateQ, stateD;
  logic errorQ;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE:   if (start && opOk) stateD = ST_READ;
      ST_READ:   stateD = ST_MODIFY;
      ST_MODIFY: stateD = cmpMiss ? ST_DONE : ST_WRITE;
      ST_WRITE:  stateD = ST_DONE;
      ST_DONE:   stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      errorQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      errorQ <= (stateQ == ST_IDLE) && start && !opOk;
    end
  end

  always_comb begin
    strobe.latchOp = (stateQ == ST_IDLE) && start && opOk;
    strobe.readEn  = (stateQ == ST_READ);
    strobe.capture = (stateQ == ST_MODIFY);
    strobe.writeEn = (stateQ == ST_WRITE);
    strobe.finish  = (stateQ == ST_DONE);
  end

  assign lock  = (stateQ == ST_READ) || (stateQ == ST_MODIFY) || (stateQ == ST_WRITE);
  assign busy  = (stateQ != ST_IDLE);
  assign error = errorQ;

  // R1: a single read per accepted operation
  p_single_read_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.readEn |=> !strobe.readEn);
  // R2: a write is always preceded by a locked cycle
  p_write_after_lock_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeEn |-> $past(lock));
  // R2: completion returns the unit to idle
  p_done_closes_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> !busy);
  // R9: a rejection touches neither lock nor completion
  p_reject_clean_r9: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (!lock && !strobe.finish && !busy));
  // R10: start during an operation never launches a read
  p_busy_ignores_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> !strobe.readEn);
endmodule

// File: rtl/atomic_rmw_dp.sv
module atomic_rmw_dp
  import atomic_rmw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rmwStrobe_t        strobe,
  input  logic [1:0]        sizeCode,
  input  logic [IMM_W-1:0]  opImm,
  input  logic [DATA_W-1:0] dstBase,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] r0Val,
  input  logic [DATA_W-1:0] memRdata,
  output logic              opOk,
  output logic              cmpMiss,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [BE_W-1:0]   memBe,
  output logic [DATA_W-1:0] srcOut,
  output logic              srcWe,
  output logic [DATA_W-1:0] r0Out,
  output logic              r0We
);
  logic [DATA_W-1:0] addrQ, srcQ, r0Q, oldQ, newQ;
  logic [7:0]        immQ;
  logic              wordQ;
  logic [DATA_W-1:0] oldExt, r0Cmp, newVal;
  logic              isCmpx;

  assign opOk = opLegal(sizeCode, opImm);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0; srcQ <= '0; r0Q <= '0; immQ <= '0; wordQ <= 1'b0;
      oldQ  <= '0; newQ <= '0;
    end else begin
      if (strobe.latchOp) begin
        addrQ <= dstBase + {{(DATA_W-OFF_W){offset[OFF_W-1]}}, offset};
        immQ  <= opImm[7:0];
        wordQ <= (sizeCode == SIZE_WORD);
        srcQ  <= srcVal;
        r0Q   <= r0Val;
      end
      if (strobe.capture) begin
        oldQ <= oldExt;
        newQ <= newVal;
      end
    end
  end

  assign isCmpx = ({immQ[7:1], 1'b0} == OP_CMPX);
  assign oldExt = wordQ ? {{HALF_W{1'b0}}, memRdata[HALF_W-1:0]} : memRdata;
  assign r0Cmp  = wordQ ? {{HALF_W{1'b0}}, r0Q[HALF_W-1:0]} : r0Q;
  assign cmpMiss = isCmpx && (oldExt != r0Cmp);

  always_comb begin
    case ({immQ[7:1], 1'b0})
      OP_ADD:  newVal = memRdata + srcQ;
      OP_OR:   newVal = memRdata | srcQ;
      OP_AND:  newVal = memRdata & srcQ;
      OP_XOR:  newVal = memRdata ^ srcQ;
      default: newVal = srcQ;
    endcase
  end

  assign memAddr  = addrQ;
  assign memWdata = wordQ ? {{HALF_W{1'b0}}, newQ[HALF_W-1:0]} : newQ;
  assign memBe    = wordQ ? {{(BE_W/2){1'b0}}, {(BE_W/2){1'b1}}} : {BE_W{1'b1}};
  assign srcOut   = oldQ;
  assign r0Out    = oldQ;
  assign srcWe    = strobe.finish && immQ[0] && !isCmpx;
  assign r0We     = strobe.finish && isCmpx;

  // R1: the write goes to the address that was read
  p_addr_held_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.writeEn |-> $stable(memAddr));
  // R4: returned word values carry no upper bits
  p_word_zero_ext_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((srcWe || r0We) && wordQ) |-> (srcOut[DATA_W-1:HALF_W] == '0));
  // R7: compare-exchange returns only to the accumulator
  p_cmpx_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    r0We |-> !srcWe);
endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atomic_rmw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        sizeCode,
  input  logic [IMM_W-1:0]  opImm,
  input  logic [DATA_W-1:0] dstBase,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] r0Val,
  output logic              busy,
  output logic              lock,
  output logic              done,
  output logic              error,
  output logic [DATA_W-1:0] memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [BE_W-1:0]   memBe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] srcOut,
  output logic              srcWe,
  output logic [DATA_W-1:0] r0Out,
  output logic              r0We
);
  rmwStrobe_t strobe;
  logic opOk, cmpMiss;

  atomic_rmw_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opOk(opOk), .cmpMiss(cmpMiss),
    .strobe(strobe), .lock(lock), .busy(busy), .error(error)
  );

  atomic_rmw_dp i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sizeCode(sizeCode), .opImm(opImm),
    .dstBase(dstBase), .offset(offset), .srcVal(srcVal), .r0Val(r0Val),
    .memRdata(memRdata), .opOk(opOk), .cmpMiss(cmpMiss), .memAddr(memAddr),
    .memWdata(memWdata), .memBe(memBe), .srcOut(srcOut), .srcWe(srcWe),
    .r0Out(r0Out), .r0We(r0We)
  );

  assign memRe = strobe.readEn;
  assign memWe = strobe.writeEn;
  assign done  = strobe.finish;
endmodule

// File: tb/test_atomic_rmw_unit.sv
module test_atomic_rmw_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [1:0]  sizeCode = '0;
  logic [31:0] opImm = '0;
  logic [63:0] dstBase = '0, srcVal = '0, r0Val = '0;
  logic [15:0] offset = '0;
  logic busy, lock, done, error, memRe, memWe, srcWe, r0We;
  logic [63:0] memAddr, memWdata, srcOut, r0Out;
  logic [63:0] memRdata = '0;
  logic [7:0]  memBe;

  logic [63:0] mem [16];
  logic        seedEn = 1'b0;
  logic [3:0]  seedIdx = '0;
  logic [63:0] seedVal = '0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_rmw_unit i_atomic_rmw_unit (.*);

  always @(posedge clk) begin
    if (seedEn) mem[seedIdx] <= seedVal;
    if (memWe)
      for (int b = 0; b < 8; b++)
        if (memBe[b]) mem[memAddr[6:3]][8*b +: 8] <= memWdata[8*b +: 8];
    if (memRe) memRdata <= mem[memAddr[6:3]];
  end

  task automatic check(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic seed(input logic [3:0] idx, input logic [63:0] val);
    @(negedge clk); seedEn = 1'b1; seedIdx = idx; seedVal = val;
    @(negedge clk); seedEn = 1'b0;
  endtask

  function automatic bit legalRef(input logic [1:0] sz, input logic [31:0] imm);
    bit ok;
    ok = (imm[31:8] == 0) && (imm[7:0] inside {8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51,
                                                 8'ha0, 8'ha1, 8'he1, 8'hf1});
    return ok && (sz == 2'd0 || sz == 2'd3);
  endfunction

  function automatic logic [63:0] newRef(input logic [7:0] imm, input logic [63:0] m, input logic [63:0] s);
    case (imm & 8'hfe)
      8'h00:   return m + s;
      8'h40:   return m | s;
      8'h50:   return m & s;
      8'ha0:   return m ^ s;
      default: return s;
    endcase
  endfunction

  task automatic doOp(input logic [1:0] sz, input logic [31:0] imm, input logic [63:0] dst,
                      input logic [15:0] off, input logic [63:0] src, input logic [63:0] r0v,
                      input bit pokeBusy);
    logic [63:0] addr, m, oldE, nv, expMem;
    bit legal, isW, cmpx, xchg, match, wr;
    int reads, writes, lockCnt, doneAt, errAt;
    string memTag;
    addr = dst + {{48{off[15]}}, off};
    m = mem[addr[6:3]];
    legal = legalRef(sz, imm);
    isW = (sz == 2'd0);
    cmpx = (imm[7:0] == 8'hf1);
    xchg = (imm[7:0] == 8'he1);
    oldE = isW ? {32'h0, m[31:0]} : m;
    match = isW ? (m[31:0] == r0v[31:0]) : (m == r0v);
    wr = legal && !(cmpx && !match);
    nv = newRef(imm[7:0], m, src);
    expMem = !wr ? m : (isW ? {m[63:32], nv[31:0]} : nv);
    memTag = cmpx ? "R7" : (xchg ? "R6" : (isW ? "R4" : "R3"));

    @(negedge clk);
    sizeCode = sz; opImm = imm; dstBase = dst; offset = off; srcVal = src; r0Val = r0v;
    start = 1'b1;
    reads = 0; writes = 0; lockCnt = 0; doneAt = 0; errAt = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == 1 && pokeBusy) begin
        opImm = 32'h50; srcVal = ~src; dstBase = dst + 64'h8; r0Val = ~r0v;
      end else begin
        start = 1'b0;
      end
      if (memRe) begin
        reads++;
        check("R1 address", memAddr == addr, memAddr, addr);
        check("R2 read cycle", k == 1, k, 1);
      end
      if (memWe) begin
        writes++;
        check("R2 write cycle", k == 3, k, 3);
        check("R4 strobes", memBe == (isW ? 8'h0F : 8'hFF), memBe, isW ? 8'h0F : 8'hFF);
      end
      if (lock) lockCnt++;
      if (error && errAt == 0) errAt = k;
      if (done && doneAt == 0) begin
        doneAt = k;
        check("R2 unlocked at done", !lock, lock, 0);
        check("R5 srcWe", srcWe == (legal && imm[0] && !cmpx), srcWe, legal && imm[0] && !cmpx);
        if (srcWe) check("R5 srcOut old value", srcOut == oldE, srcOut, oldE);
        check("R7 r0We", r0We == cmpx, r0We, cmpx);
        if (r0We) check("R7 r0Out old value", r0Out == oldE, r0Out, oldE);
      end
    end
    start = 1'b0;
    if (!legal) begin
      check("R9 error pulse", errAt == 1, errAt, 1);
      check("R9 no bus access", reads == 0 && writes == 0 && doneAt == 0, reads + writes + doneAt, 0);
    end else begin
      check("R10 one read", reads == 1, reads, 1);
      check(wr ? "R1 one write" : "R8 no write", writes == (wr ? 1 : 0), writes, wr ? 1 : 0);
      check(wr ? "R2 done cycle" : "R8 done cycle", doneAt == (wr ? 4 : 3), doneAt, wr ? 4 : 3);
      check("R2 lock span", lockCnt == (wr ? 3 : 2), lockCnt, wr ? 3 : 2);
      check("R9 no error", errAt == 0, errAt, 0);
    end
    check(memTag, mem[addr[6:3]] == expMem, mem[addr[6:3]], expMem);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R2 watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] legalOps [10];
    legalOps = '{8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51, 8'ha0, 8'ha1, 8'he1, 8'hf1};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R2 reset idle", !busy && !lock && !done && !error && !memWe && !memRe, busy, 0);
    rstN = 1'b1;
    for (int i = 0; i < 16; i++) seed(i[3:0], {$urandom, $urandom});

    // R3: dword add carrying across bit 32, with fetch (R5)
    seed(4'd2, 64'h0000_0000_FFFF_FFFF);
    doOp(2'd3, 32'h01, 64'h1000, 16'h0010, 64'h1, 64'h0, 1'b0);
    // R4: word add wraps in the low half and keeps the upper half
    seed(4'd3, 64'hDEAD_BEEF_FFFF_FFFF);
    doOp(2'd0, 32'h01, 64'h1018, 16'h0000, 64'h2, 64'h0, 1'b0);
    // R1: negative displacement
    doOp(2'd3, 32'ha0, 64'h1040, 16'hFFF0, 64'hF0F0, 64'h0, 1'b0);
    // R5: no fetch
    doOp(2'd3, 32'h40, 64'h1000, 16'h0020, 64'h8000_0000_0000_0001, 64'h0, 1'b0);
    // R6: word exchange
    doOp(2'd0, 32'he1, 64'h1000, 16'h0028, 64'h1234_5678_9ABC_DEF0, 64'h0, 1'b0);
    // R7: dword compare-exchange match and R8 mismatch
    seed(4'd6, 64'h5555_AAAA_1111_2222);
    doOp(2'd3, 32'hf1, 64'h1030, 16'h0000, 64'h77, 64'h5555_AAAA_1111_2222, 1'b0);
    doOp(2'd3, 32'hf1, 64'h1030, 16'h0000, 64'h99, 64'h1, 1'b0);
    // R7: word compare matches on the low half only
    seed(4'd7, 64'hFFFF_0000_CAFE_F00D);
    doOp(2'd0, 32'hf1, 64'h1038, 16'h0000, 64'h4242, 64'h1234_5678_CAFE_F00D, 1'b0);
    // R9: illegal sizes and selectors
    doOp(2'd1, 32'h00, 64'h1000, 16'h0, 64'h1, 64'h0, 1'b0);
    doOp(2'd2, 32'h01, 64'h1000, 16'h0, 64'h1, 64'h0, 1'b0);
    doOp(2'd3, 32'he0, 64'h1000, 16'h0, 64'h1, 64'h0, 1'b0);
    doOp(2'd3, 32'h100, 64'h1000, 16'h0, 64'h1, 64'h0, 1'b0);
    doOp(2'd0, 32'h02, 64'h1000, 16'h0, 64'h1, 64'h0, 1'b0);
    // R10: start raised again during the read cycle
    doOp(2'd3, 32'h01, 64'h1000, 16'h0008, 64'h3, 64'h0, 1'b1);
    doOp(2'd0, 32'hf1, 64'h1000, 16'h0008, 64'h5, 64'h0, 1'b1);

    for (int n = 0; n < 200; n++) begin
      logic [1:0] sz;
      logic [31:0] imm;
      logic [15:0] off;
      logic [63:0] dst, r0v, a;
      sz = ($urandom % 2 == 0) ? 2'd0 : 2'd3;
      imm = {24'h0, legalOps[$urandom % 10]};
      dst = 64'h2000 + {$urandom % 32, 3'b000};
      off = {$urandom % 64, 3'b000} - 16'd256;
      a = dst + {{48{off[15]}}, off};
      r0v = ($urandom % 2 == 0) ? mem[a[6:3]] : {$urandom, $urandom};
      doOp(sz, imm, dst, off, {$urandom, $urandom}, r0v, ($urandom % 8) == 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule